// File: doc/BRIEF.md
# Multi-Mode Operand Fetch Unit

This block resolves one source operand for an instruction whose addressing mode has already been decoded. A start pulse captures the mode code, a 16-bit field, two register selects, a scale exponent and the current program counter. The unit then forms an effective address and runs zero, one or two reads on a synchronous memory port. When it finishes, it raises a one-cycle done pulse and presents the operand, the number of memory trips it used and an error flag.

The unit has a small internal register array that stands in for the machine's register file. While the unit is idle, the array is loaded through a simple write port. In the two auto-modify modes, the unit itself updates the selected base register, and the new value also appears on write-back outputs during the done cycle. All address arithmetic is carried out modulo 2^ADDR_W.

Top module: `opfetch_unit`

## Requirements
- R1: A start pulse seen while idle latches all request inputs. busy is high from the next cycle up to and including the done cycle. done lasts exactly one cycle, and busy is low in the cycle after it.
- R2: Mode code 0 (immediate) returns the field itself, and mode code 1 (register) returns the content of the register selected by baseSel. Both report trips = 0 and issue no memory request.
- R3: Mode code 2 (direct) reads memory once, at the low ADDR_W bits of the field, and returns that word with trips = 1.
- R4: Mode code 3 (indirect) reads a pointer at the field address, then reads the operand at the pointer's low ADDR_W bits. It reports trips = 2.
- R5: Mode code 4 (register-indirect) reads once at the base register's low ADDR_W bits. Mode 5 with a zero field gives the same address, operand and trip count.
- R6: Mode code 5 (base plus displacement) reads at base + field. The field is a two's complement value, so a negative field addresses below the base.
- R7: Mode code 6 (scaled index) reads at base + (index register << scaleLog2). This gives element sizes of 1, 2, 4 or 8 words.
- R8: Mode code 7 (PC-relative) reads at pcIn + field, with the field signed, so targets can lie ahead of or behind the program counter.
- R9: Mode code 9 (pre-decrement) reads at base − STEP and writes base − STEP back into the base register. Mode code 8 (post-increment) reads at the unchanged base and writes base + STEP back. The write-back is visible on wbValid/wbSel/wbValue in the done cycle, and the register holds the new value after that cycle.
- R10: Every effective address, and every written-back value, is taken modulo 2^ADDR_W.
- R11: Mode codes 10 to 15 finish with operand 0, errFlag high together with done, trips = 0 and no memory request.
- R12: memReq is high for exactly one cycle per trip, with memAddr valid in that cycle. memData is taken in the following cycle and memAddr holds steady through it. Two requests never occur in back-to-back cycles.
- R13: A start pulse that arrives while busy is ignored. The operation in progress completes with its originally latched inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken only when idle |
| mode | input | 4 | Addressing mode code |
| field | input | DATA_W | Immediate, absolute address or signed displacement |
| baseSel | input | SEL_W | Base register select |
| indexSel | input | SEL_W | Index register select for scaled mode |
| scaleLog2 | input | 2 | Log2 of the element size for scaled mode |
| pcIn | input | ADDR_W | Program counter value |
| regWrEn | input | 1 | Register preload strobe, honoured only when idle |
| regWrSel | input | SEL_W | Register preload select |
| regWrData | input | DATA_W | Register preload data |
| memReq | output | 1 | Memory read request |
| memAddr | output | ADDR_W | Memory read address |
| memData | input | DATA_W | Memory read data, one cycle after memReq |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| operand | output | DATA_W | Fetched operand, valid with done |
| trips | output | 2 | Memory reads used, valid with done |
| errFlag | output | 1 | Unsupported mode, valid with done |
| wbValid | output | 1 | Base register update committed this cycle |
| wbSel | output | SEL_W | Register being updated |
| wbValue | output | DATA_W | New base register value |

## Verification
The hardest situation to reach is a pair of auto-modify operations that share one base register. Here the second access must see the value committed by the first, and a later register-mode read must confirm the final value. The vector table reaches this by running pre-decrement, then post-increment, then a register read on the same stack register, in that order. Wrap-around also needs deliberate setup: a base register is preloaded near the top of the address space, and a PC-relative fetch uses a negative offset from a small program counter. A separate directed case fires a second start while the first request's memory read is outstanding, to confirm that the second start is ignored.

// File: rtl/opfetch_pkg.sv
package opfetch_pkg;

  typedef enum logic [3:0] {
    MD_IMM     = 4'd0,
    MD_REG     = 4'd1,
    MD_DIR     = 4'd2,
    MD_IND     = 4'd3,
    MD_RIND    = 4'd4,
    MD_DISP    = 4'd5,
    MD_SCALED  = 4'd6,
    MD_PCREL   = 4'd7,
    MD_POSTINC = 4'd8,
    MD_PREDEC  = 4'd9
  } modeT;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;    // capture request inputs
    logic calcEa;   // register effective address and zero-trip result
    logic issueRd;  // drive a memory read request
    logic capPtr;   // pointer from memory becomes the next address
    logic capData;  // memory word becomes the operand
    logic finish;   // done cycle, commit write-back
  } strobeT;

  function automatic logic modeLegal(input logic [3:0] m);
    return m <= 4'd9;
  endfunction

  function automatic logic modeNoTrip(input logic [3:0] m);
    return (m == MD_IMM) || (m == MD_REG);
  endfunction

  function automatic logic modeAuto(input logic [3:0] m);
    return (m == MD_POSTINC) || (m == MD_PREDEC);
  endfunction

endpackage

// File: rtl/opfetch_agen.sv
module opfetch_agen
  import opfetch_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int STEP   = 1
) (
  input  logic [3:0]        modeQ,
  input  logic [ADDR_W-1:0] fieldA,
  input  logic [ADDR_W-1:0] baseA,
  input  logic [ADDR_W-1:0] idxA,
  input  logic [1:0]        scaleQ,
  input  logic [ADDR_W-1:0] pcA,
  output logic [ADDR_W-1:0] eaNext,
  output logic [ADDR_W-1:0] wbNext
);
  // all sums are truncated to ADDR_W, so a two's complement field
  // needs no explicit sign extension
  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP);

  logic [ADDR_W-1:0] scaledIdx;
  logic [ADDR_W-1:0] baseDec;
  logic [ADDR_W-1:0] baseInc;

  assign scaledIdx = idxA << scaleQ;
  assign baseDec   = baseA - STEP_A;
  assign baseInc   = baseA + STEP_A;

  always_comb begin
    unique case (modeQ)
      MD_DIR,
      MD_IND:     eaNext = fieldA;
      MD_RIND,
      MD_POSTINC: eaNext = baseA;
      MD_DISP:    eaNext = baseA + fieldA;
      MD_SCALED:  eaNext = baseA + scaledIdx;
      MD_PCREL:   eaNext = pcA + fieldA;
      MD_PREDEC:  eaNext = baseDec;
      default:    eaNext = '0;
    endcase
  end

  always_comb begin
    unique case (modeQ)
      MD_POSTINC: wbNext = baseInc;
      MD_PREDEC:  wbNext = baseDec;
      default:    wbNext = baseA;
    endcase
  end
endmodule

// File: rtl/opfetch_ctrl.sv
module opfetch_ctrl
  import opfetch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [3:0] modeQ,
  output strobeT     stb,
  output logic       busy,
  output logic       done,
  output logic [1:0] trips,
  output logic       errFlag,
  output logic       memReq
);
  typedef enum logic [2:0] {
    S_IDLE, S_CALC, S_REQ1, S_WAIT1, S_REQ2, S_WAIT2, S_DONE
  } stateT;

  stateT state, stateNext;
  logic [1:0] tripCnt;
  logic       errQ;

  always_comb begin
    stateNext = state;
    stb       = '0;
    unique case (state)
      S_IDLE: if (start) begin
        stb.latch = 1'b1;
        stateNext = S_CALC;
      end
      S_CALC: begin
        stb.calcEa = 1'b1;
        if (!modeLegal(modeQ) || modeNoTrip(modeQ)) stateNext = S_DONE;
        else                                          stateNext = S_REQ1;
      end
      S_REQ1: begin
        stb.issueRd = 1'b1;
        stateNext   = S_WAIT1;
      end
      S_WAIT1: begin
        if (modeQ == MD_IND) begin
          stb.capPtr = 1'b1;
          stateNext  = S_REQ2;
        end else begin
          stb.capData = 1'b1;
          stateNext   = S_DONE;
        end
      end
      S_REQ2: begin
        stb.issueRd = 1'b1;
        stateNext   = S_WAIT2;
      end
      S_WAIT2: begin
        stb.capData = 1'b1;
        stateNext   = S_DONE;
      end
      S_DONE: begin
        stb.finish = 1'b1;
        stateNext  = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      tripCnt <= '0;
      errQ    <= 1'b0;
    end else begin
      state <= stateNext;
      if (stb.latch) begin
        tripCnt <= '0;
        errQ    <= 1'b0;
      end else begin
        if (stb.issueRd) tripCnt <= tripCnt + 2'd1;
        if (stb.calcEa)  errQ    <= !modeLegal(modeQ);
      end
    end
  end

  assign busy    = (state != S_IDLE);
  assign done    = stb.finish;
  assign trips   = tripCnt;
  assign errFlag = stb.finish && errQ;
  assign memReq  = stb.issueRd;

  // R1: done is a single-cycle pulse and returns the unit to idle
  a_r1_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));
  // R1: a start taken while idle raises busy next cycle
  a_r1_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  // R12: no back-to-back read requests
  a_r12_req_spacing: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);
  // R11: an error completion used no memory trip
  a_r11_err_no_trip: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (done && trips == 2'd0));
  // R4: never more than two trips per operation
  a_r4_trip_bound: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (trips <= 2'd2));
endmodule

// File: rtl/opfetch_dp.sv
module opfetch_dp
  import opfetch_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10,
  parameter int NREG   = 8,
  parameter int STEP   = 1,
  localparam int SEL_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic              busy,
  input  logic [3:0]        modeIn,
  input  logic [DATA_W-1:0] fieldIn,
  input  logic [SEL_W-1:0]  baseSelIn,
  input  logic [SEL_W-1:0]  idxSelIn,
  input  logic [1:0]        scaleIn,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic              regWrEn,
  input  logic [SEL_W-1:0]  regWrSel,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] memData,
  output logic [3:0]        modeQ,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] operand,
  output logic              wbValid,
  output logic [SEL_W-1:0]  wbSel,
  output logic [DATA_W-1:0] wbValue
);
  logic [DATA_W-1:0] fieldQ;
  logic [SEL_W-1:0]  baseSelQ;
  logic [SEL_W-1:0]  idxSelQ;
  logic [1:0]        scaleQ;
  logic [ADDR_W-1:0] pcQ;
  logic [ADDR_W-1:0] eaQ;
  logic [ADDR_W-1:0] wbQ;
  logic [DATA_W-1:0] resultQ;
  logic [DATA_W-1:0] regFile [NREG];

  logic [DATA_W-1:0] baseVal;
  logic [ADDR_W-1:0] idxA;
  logic [ADDR_W-1:0] eaNext;
  logic [ADDR_W-1:0] wbNext;

  assign baseVal = regFile[baseSelQ];
  assign idxA    = regFile[idxSelQ][ADDR_W-1:0];

  opfetch_agen #(.ADDR_W(ADDR_W), .STEP(STEP)) u_agen (
    .modeQ  (modeQ),
    .fieldA (fieldQ[ADDR_W-1:0]),
    .baseA  (baseVal[ADDR_W-1:0]),
    .idxA   (idxA),
    .scaleQ (scaleQ),
    .pcA    (pcQ),
    .eaNext (eaNext),
    .wbNext (wbNext)
  );

  // request capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= '0;
      fieldQ   <= '0;
      baseSelQ <= '0;
      idxSelQ  <= '0;
      scaleQ   <= '0;
      pcQ      <= '0;
    end else if (stb.latch) begin
      modeQ    <= modeIn;
      fieldQ   <= fieldIn;
      baseSelQ <= baseSelIn;
      idxSelQ  <= idxSelIn;
      scaleQ   <= scaleIn;
      pcQ      <= pcIn;
    end
  end

  // address and result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eaQ     <= '0;
      wbQ     <= '0;
      resultQ <= '0;
    end else begin
      if (stb.calcEa) begin
        eaQ <= eaNext;
        wbQ <= wbNext;
        if (modeQ == MD_IMM)      resultQ <= fieldQ;
        else if (modeQ == MD_REG) resultQ <= baseVal;
        else                      resultQ <= '0;
      end
      if (stb.capPtr)  eaQ     <= memData[ADDR_W-1:0];
      if (stb.capData) resultQ <= memData;
    end
  end

  // register array: preload when idle, auto-modify commit in done cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regFile[i] <= '0;
    end else if (wbValid) begin
      regFile[baseSelQ] <= wbValue;
    end else if (regWrEn && !busy) begin
      regFile[regWrSel] <= regWrData;
    end
  end

  assign memAddr = eaQ;
  assign operand = resultQ;
  assign wbValid = stb.finish && modeAuto(modeQ);
  assign wbSel   = baseSelQ;
  assign wbValue = DATA_W'(wbQ);

  // R12: the request address holds through the data cycle
  a_r12_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    stb.issueRd |=> $stable(memAddr));
  // R9: the committed value is visible in the register array next cycle
  a_r9_wb_lands: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |=> (regFile[$past(wbSel)] == $past(wbValue)));
  // R13: latched request fields do not move while busy
  a_r13_fields_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !stb.finish) |=> ($stable(modeQ) && $stable(fieldQ)));
endmodule

// File: rtl/opfetch_unit.sv
module opfetch_unit
  import opfetch_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10,
  parameter int NREG   = 8,
  parameter int STEP   = 1,
  localparam int SEL_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [3:0]        mode,
  input  logic [DATA_W-1:0] field,
  input  logic [SEL_W-1:0]  baseSel,
  input  logic [SEL_W-1:0]  indexSel,
  input  logic [1:0]        scaleLog2,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic              regWrEn,
  input  logic [SEL_W-1:0]  regWrSel,
  input  logic [DATA_W-1:0] regWrData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memData,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] operand,
  output logic [1:0]        trips,
  output logic              errFlag,
  output logic              wbValid,
  output logic [SEL_W-1:0]  wbSel,
  output logic [DATA_W-1:0] wbValue
);
  strobeT     stb;
  logic [3:0] modeQ;

  opfetch_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .modeQ   (modeQ),
    .stb     (stb),
    .busy    (busy),
    .done    (done),
    .trips   (trips),
    .errFlag (errFlag),
    .memReq  (memReq)
  );

  opfetch_dp #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .NREG   (NREG),
    .STEP   (STEP)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busy      (busy),
    .modeIn    (mode),
    .fieldIn   (field),
    .baseSelIn (baseSel),
    .idxSelIn  (indexSel),
    .scaleIn   (scaleLog2),
    .pcIn      (pcIn),
    .regWrEn   (regWrEn),
    .regWrSel  (regWrSel),
    .regWrData (regWrData),
    .memData   (memData),
    .modeQ     (modeQ),
    .memAddr   (memAddr),
    .operand   (operand),
    .wbValid   (wbValid),
    .wbSel     (wbSel),
    .wbValue   (wbValue)
  );

  // R11: an unsupported mode always completes with a zero operand
  a_r11_err_zero: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (operand == '0));
  // R9: write-back only accompanies a completion
  a_r9_wb_with_done: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (done && !errFlag));
endmodule

// File: tb/opfetch_unit_tb.sv
`timescale 1ns/1ps
module opfetch_unit_tb;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 10;
  localparam int NREG   = 8;
  localparam int SEL_W  = 3;
  localparam int MEMSZ  = 1 << ADDR_W;

  typedef struct packed {
    logic [3:0]        md;
    logic [15:0]       fld;
    logic [2:0]        bsel;
    logic [2:0]        isel;
    logic [1:0]        scl;
    logic [9:0]        pc;
    logic [15:0]       expOp;
    logic [1:0]        expTrips;
    logic              expErr;
    logic              expWb;
    logic [15:0]       expWbVal;
  } vecT;

  localparam int NVEC = 16;
  localparam vecT VECS [NVEC] = '{
    '{4'd0, 16'd1234,   3'd0, 3'd0, 2'd0, 10'd0,   16'd1234, 2'd0, 1'b0, 1'b0, 16'd0},   // R2 immediate
    '{4'd1, 16'd0,      3'd1, 3'd0, 2'd0, 10'd0,   16'd400,  2'd0, 1'b0, 1'b0, 16'd0},   // R2 register
    '{4'd2, 16'd100,    3'd0, 3'd0, 2'd0, 10'd0,   16'd500,  2'd1, 1'b0, 1'b0, 16'd0},   // R3 direct
    '{4'd3, 16'd100,    3'd0, 3'd0, 2'd0, 10'd0,   16'd800,  2'd2, 1'b0, 1'b0, 16'd0},   // R4 indirect
    '{4'd4, 16'd0,      3'd1, 3'd0, 2'd0, 10'd0,   16'd700,  2'd1, 1'b0, 1'b0, 16'd0},   // R5 reg-indirect
    '{4'd5, 16'hFFFB,   3'd3, 3'd0, 2'd0, 10'd0,   16'd900,  2'd1, 1'b0, 1'b0, 16'd0},   // R6 408-5
    '{4'd5, 16'd0,      3'd1, 3'd0, 2'd0, 10'd0,   16'd700,  2'd1, 1'b0, 1'b0, 16'd0},   // R5 zero disp
    '{4'd6, 16'd0,      3'd6, 3'd2, 2'd2, 10'd0,   16'd333,  2'd1, 1'b0, 1'b0, 16'd0},   // R7 596+3*4
    '{4'd7, 16'd4,      3'd0, 3'd0, 2'd0, 10'd200, 16'd44,   2'd1, 1'b0, 1'b0, 16'd0},   // R8 forward
    '{4'd7, 16'hFFFC,   3'd0, 3'd0, 2'd0, 10'd2,   16'd88,   2'd1, 1'b0, 1'b0, 16'd0},   // R8 backward, R10 wrap
    '{4'd5, 16'd10,     3'd7, 3'd0, 2'd0, 10'd0,   16'd66,   2'd1, 1'b0, 1'b0, 16'd0},   // R10 1020+10
    '{4'd9, 16'd0,      3'd5, 3'd0, 2'd0, 10'd0,   16'd77,   2'd1, 1'b0, 1'b1, 16'd599}, // R9 push
    '{4'd8, 16'd0,      3'd5, 3'd0, 2'd0, 10'd0,   16'd77,   2'd1, 1'b0, 1'b1, 16'd600}, // R9 pop
    '{4'd1, 16'd0,      3'd5, 3'd0, 2'd0, 10'd0,   16'd600,  2'd0, 1'b0, 1'b0, 16'd0},   // R9 final SP
    '{4'd12, 16'd55,    3'd0, 3'd0, 2'd0, 10'd0,   16'd0,    2'd0, 1'b1, 1'b0, 16'd0},   // R11 illegal
    '{4'd3, 16'd200,    3'd0, 3'd0, 2'd0, 10'd0,   16'd331,  2'd2, 1'b0, 1'b0, 16'd0}    // R4 second chain
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [3:0]        mode = '0;
  logic [DATA_W-1:0] field = '0;
  logic [SEL_W-1:0]  baseSel = '0;
  logic [SEL_W-1:0]  indexSel = '0;
  logic [1:0]        scaleLog2 = '0;
  logic [ADDR_W-1:0] pcIn = '0;
  logic              regWrEn = 1'b0;
  logic [SEL_W-1:0]  regWrSel = '0;
  logic [DATA_W-1:0] regWrData = '0;
  logic              memReq;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memData = '0;
  logic              busy, done, errFlag, wbValid;
  logic [DATA_W-1:0] operand, wbValue;
  logic [1:0]        trips;
  logic [SEL_W-1:0]  wbSel;

  logic [DATA_W-1:0] mem [MEMSZ];
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  opfetch_unit u_dut (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .field(field),
    .baseSel(baseSel), .indexSel(indexSel), .scaleLog2(scaleLog2), .pcIn(pcIn),
    .regWrEn(regWrEn), .regWrSel(regWrSel), .regWrData(regWrData),
    .memReq(memReq), .memAddr(memAddr), .memData(memData),
    .busy(busy), .done(done), .operand(operand), .trips(trips),
    .errFlag(errFlag), .wbValid(wbValid), .wbSel(wbSel), .wbValue(wbValue)
  );

  // memory model, one-cycle read latency
  always @(posedge clk) if (memReq) memData <= mem[memAddr];

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string reqOf(input logic [3:0] m);
    case (m)
      4'd0, 4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      4'd8, 4'd9: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic preload(input int sel, input int val);
    @(negedge clk);
    regWrEn = 1'b1; regWrSel = SEL_W'(sel); regWrData = DATA_W'(val);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic runOp(input vecT v, input string tag, input logic midStart);
    int reqs = 0;
    int cyc = 0;
    logic busyBad = 1'b0;
    @(negedge clk);
    mode = v.md; field = v.fld; baseSel = v.bsel; indexSel = v.isel;
    scaleLog2 = v.scl; pcIn = v.pc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 40) begin
      if (!busy) busyBad = 1'b1;
      if (memReq) reqs++;
      if (midStart && cyc == 1) begin
        mode = 4'd0; field = 16'd9999; start = 1'b1;   // R13 stray start
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check("R1", {tag, " done seen"}, int'(done), 1);
    check("R1", {tag, " busy held"}, int'(busyBad), 0);
    check("R1", {tag, " busy in done"}, int'(busy), 1);
    check(midStart ? "R13" : reqOf(v.md), {tag, " operand"}, int'(operand), int'(v.expOp));
    check(reqOf(v.md), {tag, " trips"}, int'(trips), int'(v.expTrips));
    check("R12", {tag, " request count"}, reqs, int'(v.expTrips));
    check("R11", {tag, " errFlag"}, int'(errFlag), int'(v.expErr));
    check("R9", {tag, " wbValid"}, int'(wbValid), int'(v.expWb));
    if (v.expWb) begin
      check("R9", {tag, " wbSel"}, int'(wbSel), int'(v.bsel));
      check("R9", {tag, " wbValue"}, int'(wbValue), int'(v.expWbVal));
    end
    @(negedge clk);
    check("R1", {tag, " done single"}, int'(done), 0);
    check("R1", {tag, " idle after"}, int'(busy), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < MEMSZ; i++) mem[i] = DATA_W'(i * 3 + 7);
    mem[100] = 500;  mem[200] = 108;  mem[400] = 700;  mem[403] = 900;
    mem[404] = 111;  mem[408] = 222;  mem[500] = 800;  mem[596] = 42;
    mem[599] = 77;   mem[600] = 55;   mem[608] = 333;  mem[204] = 44;
    mem[1022] = 88;  mem[6] = 66;

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "reset busy", int'(busy), 0);
    check("R1", "reset done", int'(done), 0);
    check("R12", "reset memReq", int'(memReq), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "post-reset operand", int'(operand), 0);
    check("R1", "post-reset busy", int'(busy), 0);

    preload(1, 400); preload(2, 3);   preload(3, 408); preload(4, 0);
    preload(5, 600); preload(6, 596); preload(7, 1020);

    for (int n = 0; n < NVEC; n++) begin
      runOp(VECS[n], $sformatf("vec%0d", n), 1'b0);
    end

    // R13 start while busy: direct fetch at 100 must still return 500
    runOp(VECS[2], "busy-start", 1'b1);

    // R10 pre-decrement wraps below zero: R4=0 -> EA 1023, written back 1023
    mem[1023] = 1234;
    runOp('{4'd9, 16'd0, 3'd4, 3'd0, 2'd0, 10'd0, 16'd1234, 2'd1, 1'b0, 1'b1, 16'd1023},
          "R10 predec wrap", 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule